// File: doc/BRIEF.md
# I/O-Port Management Interrupt Trigger with Periodic Timer

This block sits on a byte-addressed I/O-port bus and raises a management interrupt request on behalf of software and on behalf of a periodic timer. Two fixed byte ports form the software interface. The command port at 0xB2 raises a request on every write. The parameter port at 0xB3 only holds a byte, so software can pass a value to the interrupt handler. Both ports can be read back.

A second source is a periodic timer. It counts an external one-second tick and raises a request once per selected interval of 8, 16, 32 or 64 seconds. Requests from the two sources that occur in the same cycle come out as a single one-cycle pulse. A sticky cause register records which source fired, and software clears its bits by writing ones to them.

The bus carries one byte per lane. The byte address of lane k is `io_addr + k`, so a 16-bit write at 0xB2 with both enables set fills 0xB2 from lane 0 and 0xB3 from lane 1.

Top module: `smi_trigger_unit`

## Requirements
- R1: After a synchronous active-low reset, both port bytes, the rate field and the cause bits read as zero, and `smi_req` is low.
- R2: The command port is at byte address 0xB2 and the parameter port is at 0xB3. These addresses are fixed. A read returns the last byte written to each address. `io_rdata` carries the read result in the cycle after the read strobe, with lane k holding the byte at `io_addr + k`. Bytes at unmapped addresses read as zero, and `io_rdata` is zero in any cycle not preceded by a read strobe.
- R3: Any write whose enabled lanes include address 0xB2 makes `smi_req` high for one cycle, the cycle after the write strobe. The value written does not matter.
- R4: A write that stores into 0xB3 but not into 0xB2 updates the parameter byte and never raises `smi_req`.
- R5: A 16-bit write at 0xB2 with both enables set stores the low byte in 0xB2 and the high byte in 0xB3, and it raises exactly one pulse.
- R6: The rate field is bits [1:0] of the byte at 0xB4, and it can be read and written. Its values select these intervals: 00 = 64 s, 01 = 32 s, 10 = 16 s, 11 = 8 s. It resets to 00.
- R7: The timer counts `tick_sec` pulses. On the tick that completes the selected interval since the last restart, `smi_req` is high in the next cycle, and the count starts again from zero.
- R8: Any write to the rate byte restarts the count from zero. A tick in the same cycle as that write is not counted.
- R9: When a command-port write and a completing tick fall in the same cycle, they produce one single-cycle pulse.
- R10: The byte at 0xB5 holds the sticky cause bits. Bit 0 is the command port and bit 1 is the periodic timer. Each bit is set together with its pulse. Writing 1 to a bit clears it, and if a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Byte address of lane 0 |
| io_wdata | input | 16 | Write data, one byte per lane |
| io_be | input | 2 | Per-lane byte enables |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 16 | Registered read data |
| tick_sec | input | 1 | One-cycle pulse, once per second |
| smi_req | output | 1 | One-cycle management interrupt request |

## Verification
`smi_req` is due exactly one clock after the edge that samples a command-port write or a completing tick. Read data is due one clock after the read strobe. A cause bit therefore becomes visible through a read started on the cycle after the pulse. The bench drives inputs on falling edges and runs a behavioural model on each rising edge. On the following falling edge it compares `smi_req` and `io_rdata` against that model, so every comparison lands in the cycle where the registered result is due. Directed checks count pulses over windows that include that one-cycle delay, and they read registers back only after the read latency.

// File: rtl/smi_gen_pkg.sv
// Shared constants and types for the port-triggered management interrupt unit.
// Assumes byte-wide ports on a little-endian multi-lane I/O bus.
package smi_gen_pkg;
    localparam int BYTE_W = 8;
    localparam logic [15:0] APM_CTL_PORT = 16'h00B2;
    localparam logic [15:0] APM_STS_PORT = 16'h00B3;

    typedef enum logic [1:0] {
        RATE_64S = 2'b00,
        RATE_32S = 2'b01,
        RATE_16S = 2'b10,
        RATE_8S  = 2'b11
    } smi_rate_e;

    typedef struct packed {
        logic periodic;
        logic port;
    } smi_cause_t;
endpackage

// File: rtl/smi_apm_ports.sv
// Command and parameter byte registers. Holds the last byte written to each.
// Assumes the decoder presents at most one write per register per cycle.
module smi_apm_ports
    import smi_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] ctl_d,
    input  logic              sts_we,
    input  logic [BYTE_W-1:0] sts_d,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] sts_q
);
    // Store the command and parameter bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            sts_q <= '0;
        end else begin
            if (ctl_we) ctl_q <= ctl_d;
            if (sts_we) sts_q <= sts_d;
        end
    end
endmodule

// File: rtl/smi_period_timer.sv
// Periodic source: counts one-second ticks and flags the tick that completes
// the interval chosen by the rate field. A restart clears the count and
// discards a tick in the same cycle. Assumes the rate changes only on restart.
module smi_period_timer
    import smi_gen_pkg::*;
#(
    parameter int BASE_SECONDS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  smi_rate_e rate,
    input  logic      restart,
    input  logic      tick,
    output logic      fire
);
    localparam int MAX_INTERVAL = BASE_SECONDS * 8;
    localparam int CNT_W = $clog2(MAX_INTERVAL);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count for the selected interval.
    always_comb begin
        int lim;
        lim = (BASE_SECONDS << (3 - int'(rate))) - 1;
        last_cnt = CNT_W'(lim);
    end

    assign fire = tick && !restart && (cnt == last_cnt);

    // Advance, wrap or restart the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == last_cnt) ? '0 : cnt + 1'b1;
        end
    end

    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt);
    a_r7_wrap_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt == '0));
endmodule

// File: rtl/smi_cause_merge.sv
// Merges the port and periodic sources into one registered request pulse and
// keeps a sticky, write-one-to-clear cause bit per source. A set wins over a clear.
module smi_cause_merge
    import smi_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_hit,
    input  logic       timer_hit,
    input  logic       clr_we,
    input  logic [1:0] clr_mask,
    output logic       smi_req,
    output smi_cause_t cause
);
    // Register the merged request and update the cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_req <= 1'b0;
            cause   <= '0;
        end else begin
            smi_req        <= port_hit | timer_hit;
            cause.port     <= port_hit  | (cause.port     & ~(clr_we & clr_mask[0]));
            cause.periodic <= timer_hit | (cause.periodic & ~(clr_we & clr_mask[1]));
        end
    end

    a_r9_merged_single: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit && timer_hit) |=> (smi_req && cause.port && cause.periodic));
    a_r10_cause_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> (cause.port || cause.periodic));
    a_r10_clear_without_set: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[0] && !port_hit) |=> !cause.port);
endmodule

// File: rtl/smi_trigger_unit.sv
// Top of the I/O-port management interrupt trigger. Decodes the byte lanes of
// the I/O bus onto the command, parameter, rate and cause bytes, drives the
// registered read data, and combines the port and periodic sources.
// Assumes lane k addresses byte io_addr + k, and that tick_sec is a one-cycle pulse.
module smi_trigger_unit
    import smi_gen_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          LANES        = 2,
    parameter logic [15:0] CFG_ADDR     = 16'h00B4,
    parameter logic [15:0] CAUSE_ADDR   = 16'h00B5,
    parameter int          BASE_SECONDS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic [LANES*BYTE_W-1:0] io_wdata,
    input  logic [LANES-1:0]        io_be,
    input  logic                    io_wr,
    input  logic                    io_rd,
    output logic [LANES*BYTE_W-1:0] io_rdata,
    input  logic                    tick_sec,
    output logic                    smi_req
);
    localparam int DATA_W = LANES * BYTE_W;

    logic [LANES-1:0]  ctl_hit, sts_hit, cfg_hit, cause_hit;
    logic [DATA_W-1:0] rd_bytes;
    logic [BYTE_W-1:0] ctl_d, sts_d, ctl_q, sts_q;
    logic [1:0]        cfg_d, clr_d;
    logic              timer_hit;
    smi_rate_e         rate_q;
    smi_cause_t        cause_q;

    // Per-lane address decode and read byte selection.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        logic              lane_we;
        assign lane_addr    = io_addr + ADDR_W'(l);
        assign lane_we      = io_wr & io_be[l];
        assign ctl_hit[l]   = lane_we & (lane_addr == ADDR_W'(APM_CTL_PORT));
        assign sts_hit[l]   = lane_we & (lane_addr == ADDR_W'(APM_STS_PORT));
        assign cfg_hit[l]   = lane_we & (lane_addr == ADDR_W'(CFG_ADDR));
        assign cause_hit[l] = lane_we & (lane_addr == ADDR_W'(CAUSE_ADDR));

        // Select the byte seen at this lane's address.
        always_comb begin
            if (lane_addr == ADDR_W'(APM_CTL_PORT))
                rd_bytes[l*BYTE_W +: BYTE_W] = ctl_q;
            else if (lane_addr == ADDR_W'(APM_STS_PORT))
                rd_bytes[l*BYTE_W +: BYTE_W] = sts_q;
            else if (lane_addr == ADDR_W'(CFG_ADDR))
                rd_bytes[l*BYTE_W +: BYTE_W] = {6'b0, rate_q};
            else if (lane_addr == ADDR_W'(CAUSE_ADDR))
                rd_bytes[l*BYTE_W +: BYTE_W] = {6'b0, cause_q};
            else
                rd_bytes[l*BYTE_W +: BYTE_W] = '0;
        end
    end

    // Steer write data from whichever lane hits each register.
    always_comb begin
        ctl_d = '0;
        sts_d = '0;
        cfg_d = '0;
        clr_d = '0;
        for (int l = 0; l < LANES; l++) begin
            if (ctl_hit[l])   ctl_d = io_wdata[l*BYTE_W +: BYTE_W];
            if (sts_hit[l])   sts_d = io_wdata[l*BYTE_W +: BYTE_W];
            if (cfg_hit[l])   cfg_d = io_wdata[l*BYTE_W +: 2];
            if (cause_hit[l]) clr_d = io_wdata[l*BYTE_W +: 2];
        end
    end

    // Hold the periodic rate selection.
    always_ff @(posedge clk) begin
        if (!rst_n)        rate_q <= RATE_64S;
        else if (|cfg_hit) rate_q <= smi_rate_e'(cfg_d);
    end

    // Register read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     io_rdata <= '0;
        else if (io_rd) io_rdata <= rd_bytes;
        else            io_rdata <= '0;
    end

    smi_apm_ports u_ports (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_we (|ctl_hit),
        .ctl_d  (ctl_d),
        .sts_we (|sts_hit),
        .sts_d  (sts_d),
        .ctl_q  (ctl_q),
        .sts_q  (sts_q)
    );

    smi_period_timer #(.BASE_SECONDS(BASE_SECONDS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (rate_q),
        .restart (|cfg_hit),
        .tick    (tick_sec),
        .fire    (timer_hit)
    );

    smi_cause_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_hit  (|ctl_hit),
        .timer_hit (timer_hit),
        .clr_we    (|cause_hit),
        .clr_mask  (clr_d),
        .smi_req   (smi_req),
        .cause     (cause_q)
    );

    a_r3_ctl_write_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && |ctl_hit) |=> smi_req);
    a_r4_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|ctl_hit) && !tick_sec) |=> !smi_req);
    a_r5_wide_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_be == 2'b11 && io_addr == ADDR_W'(APM_CTL_PORT)) |=>
        (ctl_q == $past(io_wdata[7:0]) && sts_q == $past(io_wdata[15:8])));
    a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> (io_rdata == '0));
    a_r6_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cfg_hit) |=> $stable(rate_q));
endmodule

// File: tb/tb_smi_trigger_unit.sv
module tb_smi_trigger_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [1:0]  io_be = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_rdata;
    logic        tick_sec = 1'b0;
    logic        smi_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    always #4 clk = ~clk;

    smi_trigger_unit dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .tick_sec(tick_sec), .smi_req(smi_req)
    );

    // Behavioural reference state.
    logic [7:0]  m_ctl, m_sts;
    logic [1:0]  m_rate, m_cause;
    int          m_cnt;
    logic        e_smi;
    logic [15:0] e_rdata;

    function automatic int interval_of(logic [1:0] r);
        case (r)
            2'b00:   return 64;
            2'b01:   return 32;
            2'b10:   return 16;
            default: return 8;
        endcase
    endfunction

    function automatic logic [7:0] byte_at(logic [15:0] a);
        if (a == 16'h00B2) return m_ctl;
        if (a == 16'h00B3) return m_sts;
        if (a == 16'h00B4) return {6'b0, m_rate};
        if (a == 16'h00B5) return {6'b0, m_cause};
        return 8'h00;
    endfunction

    always @(posedge clk) begin : model
        logic phit, thit, rwr;
        logic [1:0] clr;
        if (!rst_n) begin
            m_ctl = 0; m_sts = 0; m_rate = 0; m_cause = 0; m_cnt = 0;
            e_smi = 0; e_rdata = 0;
        end else begin
            phit = 0; thit = 0; rwr = 0; clr = 0;
            e_rdata = 0;
            if (io_rd) begin
                e_rdata[7:0]  = byte_at(io_addr);
                e_rdata[15:8] = byte_at(io_addr + 16'd1);
            end
            if (io_wr) begin
                for (int k = 0; k < 2; k++) begin
                    if (io_be[k]) begin
                        case (io_addr + 16'(k))
                            16'h00B2: begin m_ctl = io_wdata[k*8 +: 8]; phit = 1; end
                            16'h00B3: m_sts = io_wdata[k*8 +: 8];
                            16'h00B4: begin m_rate = io_wdata[k*8 +: 2]; rwr = 1; end
                            16'h00B5: clr = io_wdata[k*8 +: 2];
                            default: ;
                        endcase
                    end
                end
            end
            if (rwr) m_cnt = 0;
            else if (tick_sec) begin
                m_cnt++;
                if (m_cnt == interval_of(m_rate)) begin m_cnt = 0; thit = 1; end
            end
            m_cause = (m_cause & ~clr) | {thit, phit};
            e_smi = phit | thit;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare the outputs with the reference on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3/R7/R9 smi_req vs model", {31'b0, smi_req}, {31'b0, e_smi});
            check("R2 io_rdata vs model", {16'b0, io_rdata}, {16'b0, e_rdata});
            if (smi_req) pulses++;
        end
    end

    task automatic wr(logic [15:0] a, logic [15:0] d, logic [1:0] be, logic tk = 0);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_be = be; io_wr = 1; tick_sec = tk;
        @(negedge clk);
        io_wr = 0; io_be = 0; tick_sec = 0;
    endtask

    task automatic rd(logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1;
        @(negedge clk);
        io_rd = 0;
        d = io_rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_sec = 1;
            @(negedge clk); tick_sec = 0;
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic [15:0] d;
        int p;
        idle(4);
        rst_n = 1;
        idle(1);
        check("R1 smi_req after reset", {31'b0, smi_req}, 0);
        rd(16'h00B2, d); check("R1 ports after reset", {16'b0, d}, 32'h0000);
        rd(16'h00B4, d); check("R1 R6 rate and cause after reset", {16'b0, d}, 32'h0000);

        p = pulses; wr(16'h00B2, 16'h0001, 2'b01); idle(2);
        check("R3 byte write to command port", pulses - p, 1);
        p = pulses; wr(16'h00B2, 16'h0000, 2'b01); idle(2);
        check("R3 zero value still triggers", pulses - p, 1);

        p = pulses; wr(16'h00B3, 16'h0034, 2'b01); idle(2);
        check("R4 parameter write no pulse", pulses - p, 0);
        rd(16'h00B2, d); check("R2 R4 readback pair", {16'b0, d}, 32'h3400);

        p = pulses; wr(16'h00B2, 16'h5612, 2'b11); idle(3);
        check("R5 wide write single pulse", pulses - p, 1);
        rd(16'h00B2, d); check("R5 wide write fills both", {16'b0, d}, 32'h5612);
        rd(16'h00B3, d); check("R2 lane addressing", {16'b0, d}, 32'h0056);

        p = pulses; wr(16'h00B1, 16'h7700, 2'b10); idle(2);
        check("R3 upper lane hits command port", pulses - p, 1);
        rd(16'h00B0, d); check("R2 unmapped reads zero", {16'b0, d}, 32'h0000);

        rd(16'h00B5, d); check("R10 port cause set", {16'b0, d}, 32'h0001);
        wr(16'h00B5, 16'h0001, 2'b01);
        rd(16'h00B5, d); check("R10 write one clears", {16'b0, d}, 32'h0000);

        wr(16'h00B4, 16'h0003, 2'b01);
        rd(16'h00B4, d); check("R6 rate readback", {16'b0, d}, 32'h0003);
        p = pulses; ticks(7);
        check("R7 no pulse before interval", pulses - p, 0);
        ticks(1);
        check("R7 pulse on eighth tick", pulses - p, 1);
        rd(16'h00B5, d); check("R10 periodic cause set", {16'b0, d}, 32'h0002);

        ticks(5);
        p = pulses; wr(16'h00B4, 16'h0003, 2'b01, 1'b1);
        ticks(7);
        check("R8 restart discards count and same-cycle tick", pulses - p, 0);
        ticks(1);
        check("R8 pulse a full interval after restart", pulses - p, 1);

        wr(16'h00B5, 16'h0003, 2'b01);
        ticks(7);
        p = pulses; wr(16'h00B2, 16'h0042, 2'b01, 1'b1); idle(3);
        check("R9 merged sources one pulse", pulses - p, 1);
        rd(16'h00B5, d); check("R9 R10 both causes", {16'b0, d}, 32'h0003);

        ticks(7);
        @(negedge clk); io_addr = 16'h00B5; io_wdata = 16'h0002; io_be = 2'b01;
        io_wr = 1; tick_sec = 1;
        @(negedge clk); io_wr = 0; io_be = 0; tick_sec = 0;
        rd(16'h00B5, d); check("R10 set wins over clear", {16'b0, d}, 32'h0003);

        wr(16'h00B4, 16'h0000, 2'b01);
        p = pulses; ticks(63);
        check("R6 default interval not yet", pulses - p, 0);
        ticks(1);
        check("R6 R7 pulse at sixty-four", pulses - p, 1);

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule